// File: doc/BRIEF.md
# Mixed-Sign Multiply-High Execution Unit

This execution unit serves a 32-bit RISC pipeline. It takes a register-format instruction word together with two operand values already read from the register file, recognises the mixed-sign multiply-high operation, and returns the upper half of the product. In that product the first operand is a two's-complement signed integer and the second is an unsigned integer. The result leaves the unit after a fixed number of cycles, set by a parameter, together with the destination register index taken from the instruction. The core can then write it back in issue order.

A build-time switch removes the multiplier. In that build the unit still recognises the instruction, but it raises an unimplemented-instruction flag in place of a result, with the same latency, so the exception lines up with the slot the result would have taken. Words that carry a different operation are not accepted into the pipeline and produce nothing. A new instruction can be taken on every cycle once reset has ended.

Top module: `mxh_unit`

## Requirements
- R1: With the multiplier present, a recognised instruction returns bits 63..32 of the 64-bit product of `in_op_a`, read as signed two's complement, and `in_op_b`, read as unsigned.
- R2: An instruction is recognised only when bits 5..0 equal 0x3a, bits 16..11 equal 0x17 and bits 10..6 are all zero.
- R3: `res_dest` (and the slot of `exc_unimpl`) carries bits 21..17 of the accepted instruction word.
- R4: An instruction accepted at a rising edge shows its output after the LAT-th rising edge, counting the accepting edge as the first, for one cycle, and not earlier.
- R5: An instruction word that is not recognised produces neither `res_valid` nor `exc_unimpl`.
- R6: With MUL_EN = 0, a recognised instruction raises `exc_unimpl` in its result slot and never raises `res_valid`. `res_valid` and `exc_unimpl` are never high together.
- R7: Recognised instructions offered on consecutive cycles are all accepted, and their outputs appear on consecutive cycles in issue order.
- R8: Operands 0x80000000 and 0xFFFFFFFF give a high word of 0x80000000.
- R9: While `rst_n` is low, `in_ready`, `res_valid` and `exc_unimpl` are low. `in_ready` is high from the first cycle after reset is released.
- R10: A word is taken only when `in_valid` and `in_ready` are both high. A recognised word offered with `in_valid` low produces no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Instruction and operands are offered |
| in_ready | output | 1 | Unit can take an instruction this cycle |
| in_instr | input | 32 | Register-format instruction word |
| in_op_a | input | W | First operand, signed |
| in_op_b | input | W | Second operand, unsigned |
| res_valid | output | 1 | Result and destination are valid this cycle |
| res_data | output | W | High word of the product |
| res_dest | output | 5 | Destination register index |
| exc_unimpl | output | 1 | Unimplemented-instruction exception for this slot |

## Verification
Two things can fall in the same cycle: a new instruction entering the unit, and the result of an earlier instruction leaving it. Every cycle also carries a decision between result, exception or silence. The bench streams back-to-back recognised words mixed with rejected encodings and idle slots into two instances, one with the multiplier and one without. It compares both outputs on every cycle against the slot issued LAT cycles earlier. A result that is dropped, repeated, shifted by one cycle, sent to the wrong instance type or paired with the wrong destination shows up as a mismatch in that slot.

// File: rtl/mxh_pkg.sv
// Package: encodings and the pipeline tag shared by the multiply-high unit.
// Assumes a 32-bit register-format instruction word.
package mxh_pkg;
    localparam int          INSTR_W    = 32;
    localparam int          IDX_W      = 5;
    localparam logic [5:0]  OP_PRIMARY = 6'h3a;
    localparam logic [5:0]  OP_EXT     = 6'h17;

    // Control that travels beside the data through every stage
    typedef struct packed {
        logic             valid;
        logic             exc;
        logic [IDX_W-1:0] dest;
    } mxh_tag_t;
endpackage

// File: rtl/mxh_decode.sv
// mxh_decode: recognises the multiply-high encoding and extracts the
// destination index. Purely combinational; the caller qualifies the hit
// with its handshake.
module mxh_decode
    import mxh_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output logic               hit,
    output logic [IDX_W-1:0]   dest
);
    localparam int DEST_LSB = 17;

    // Compare the primary opcode, the extended opcode and the zero field
    always_comb begin
        hit  = (instr[5:0] == OP_PRIMARY) &&
               (instr[16:11] == OP_EXT) &&
               (instr[10:6] == 5'd0);
        dest = instr[DEST_LSB +: IDX_W];
    end

    // The source indices are consumed by the register file, not here
    logic idx_src_unused;
    assign idx_src_unused = ^instr[INSTR_W-1:DEST_LSB+IDX_W];
endmodule

// File: rtl/mxh_mul_hi.sv
// mxh_mul_hi: high word of signed(a) times unsigned(b). The first operand is
// sign-extended and the second zero-extended by one bit, so a single signed
// multiply covers the mixed-sign case. The true product fits in 2*W bits.
module mxh_mul_hi #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] hi
);
    localparam int PW = 2 * W;

    logic signed [PW-1:0] prod;

    // One extended signed multiply, then keep the upper half
    always_comb begin
        prod = $signed({a[W-1], a}) * $signed({1'b0, b});
        hi   = W'(prod >>> W);
    end
endmodule

// File: rtl/mxh_pipe.sv
// mxh_pipe: LAT register stages carrying the tag and the data word.
// Assumes LAT >= 1. Every stage is cleared by the synchronous reset.
module mxh_pipe
    import mxh_pkg::*;
#(
    parameter int W   = 32,
    parameter int LAT = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  mxh_tag_t     tag_in,
    input  logic [W-1:0] data_in,
    output mxh_tag_t     tag_out,
    output logic [W-1:0] data_out
);
    localparam int LAST = LAT - 1;

    mxh_tag_t     tag_q  [LAT];
    logic [W-1:0] data_q [LAT];

    // Shift tag and data one stage per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) begin
                tag_q[i]  <= '0;
                data_q[i] <= '0;
            end
        end else begin
            tag_q[0]  <= tag_in;
            data_q[0] <= data_in;
            for (int i = 1; i < LAT; i++) begin
                tag_q[i]  <= tag_q[i-1];
                data_q[i] <= data_q[i-1];
            end
        end
    end

    assign tag_out  = tag_q[LAST];
    assign data_out = data_q[LAST];
endmodule

// File: rtl/mxh_unit.sv
// mxh_unit: mixed-sign multiply-high execution unit.
// Takes one instruction per cycle once out of reset, returns the high word
// with its destination LAT cycles later. With MUL_EN = 0 the multiplier is
// absent and the slot carries an unimplemented-instruction flag instead.
// Assumes 1 <= LAT <= 3.
module mxh_unit
    import mxh_pkg::*;
#(
    parameter int W      = 32,
    parameter int LAT    = 2,
    parameter bit MUL_EN = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [INSTR_W-1:0] in_instr,
    input  logic [W-1:0]       in_op_a,
    input  logic [W-1:0]       in_op_b,
    output logic               res_valid,
    output logic [W-1:0]       res_data,
    output logic [IDX_W-1:0]   res_dest,
    output logic               exc_unimpl
);
    logic             ready_q;
    logic             dec_hit;
    logic [IDX_W-1:0] dec_dest;
    logic [W-1:0]     hi_word;
    mxh_tag_t         tag_in;
    mxh_tag_t         tag_out;
    logic [W-1:0]     data_out;

    // Ready follows reset: low during reset, high from the next cycle
    always_ff @(posedge clk) begin
        if (!rst_n) ready_q <= 1'b0;
        else        ready_q <= 1'b1;
    end
    assign in_ready = ready_q;

    mxh_decode u_decode (
        .instr (in_instr),
        .hit   (dec_hit),
        .dest  (dec_dest)
    );

    // Multiplier present or replaced by a constant, by parameter
    if (MUL_EN) begin : g_mul
        mxh_mul_hi #(.W(W)) u_mul (
            .a  (in_op_a),
            .b  (in_op_b),
            .hi (hi_word)
        );
    end else begin : g_nomul
        logic op_unused;
        assign op_unused = ^{in_op_a, in_op_b};
        assign hi_word   = '0;
    end

    // Build the tag of the slot entering the pipeline
    always_comb begin
        tag_in.valid = in_valid && ready_q && dec_hit;
        tag_in.exc   = !MUL_EN;
        tag_in.dest  = dec_dest;
    end

    mxh_pipe #(.W(W), .LAT(LAT)) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .tag_in   (tag_in),
        .data_in  (hi_word),
        .tag_out  (tag_out),
        .data_out (data_out)
    );

    // Split the leaving slot into a result or an exception
    always_comb begin
        res_valid  = tag_out.valid && !tag_out.exc;
        exc_unimpl = tag_out.valid && tag_out.exc;
        res_data   = data_out;
        res_dest   = tag_out.dest;
    end
endmodule

// File: rtl/mxh_unit_chk.sv
// mxh_unit_chk: timing and data properties of mxh_unit, observed at its
// ports only. Attached to every instance by the bind below.
module mxh_unit_chk #(
    parameter int W      = 32,
    parameter int LAT    = 2,
    parameter bit MUL_EN = 1'b1
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         in_ready,
    input logic [31:0]  in_instr,
    input logic [W-1:0] in_op_a,
    input logic [W-1:0] in_op_b,
    input logic         res_valid,
    input logic [W-1:0] res_data,
    input logic [4:0]   res_dest,
    input logic         exc_unimpl
);
    logic                   take_now;
    logic signed [2*W-1:0]  ref_prod;
    logic [W-1:0]           ref_hi;
    logic [1:0]             since_rst;

    // Reference view of the port stimulus
    always_comb begin
        take_now = in_valid && in_ready && (in_instr[5:0] == 6'h3a) &&
                   (in_instr[16:11] == 6'h17) && (in_instr[10:6] == 5'd0);
        ref_prod = $signed({in_op_a[W-1], in_op_a}) * $signed({1'b0, in_op_b});
        ref_hi   = W'(ref_prod >>> W);
    end

    // Cycles since reset, saturating, to keep look-back inside the run
    always_ff @(posedge clk) begin
        if (!rst_n)              since_rst <= '0;
        else if (since_rst != 3) since_rst <= since_rst + 2'd1;
    end

    AST_RESULT_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> res_data == $past(ref_hi, LAT)); // R1
    AST_DEST_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid || exc_unimpl) |-> res_dest == $past(in_instr[21:17], LAT)); // R3
    AST_OUT_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid || exc_unimpl) |-> $past(take_now, LAT)); // R4
    AST_SOURCE_HAS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'(LAT)) && $past(take_now, LAT) |-> (res_valid || exc_unimpl)); // R7
    AST_NO_DOUBLE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_valid && exc_unimpl)); // R6
    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (MUL_EN == 1'b0) |-> !res_valid); // R6
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !res_valid && !exc_unimpl && !in_ready); // R9
    AST_READY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> in_ready); // R9
endmodule

bind mxh_unit mxh_unit_chk #(.W(W), .LAT(LAT), .MUL_EN(MUL_EN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_instr   (in_instr),
    .in_op_a    (in_op_a),
    .in_op_b    (in_op_b),
    .res_valid  (res_valid),
    .res_data   (res_data),
    .res_dest   (res_dest),
    .exc_unimpl (exc_unimpl)
);

// File: tb/test_mxh_unit.sv
// Directed bench: two instances share the stimulus, one with the multiplier
// and one without. Inputs change and outputs are sampled on falling edges.
module test_mxh_unit;
    localparam int LAT = 2;
    localparam int NS  = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_instr = '0;
    logic [31:0] in_op_a = '0;
    logic [31:0] in_op_b = '0;

    logic        rdy_m, val_m, exc_m;
    logic [31:0] dat_m;
    logic [4:0]  dst_m;
    logic        rdy_n, val_n, exc_n;
    logic [31:0] dat_n;
    logic [4:0]  dst_n;

    int checks = 0;
    int errors = 0;

    // Slot lists for one run
    logic [31:0] s_instr [NS];
    logic [31:0] s_a     [NS];
    logic [31:0] s_b     [NS];
    logic        s_v     [NS];
    logic        s_hit   [NS];

    always #2 clk = ~clk;

    mxh_unit #(.W(32), .LAT(LAT), .MUL_EN(1'b1)) i_mxh_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_m),
        .in_instr(in_instr), .in_op_a(in_op_a), .in_op_b(in_op_b),
        .res_valid(val_m), .res_data(dat_m), .res_dest(dst_m), .exc_unimpl(exc_m)
    );

    mxh_unit #(.W(32), .LAT(LAT), .MUL_EN(1'b0)) i_mxh_unit_nomul (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_n),
        .in_instr(in_instr), .in_op_a(in_op_a), .in_op_b(in_op_b),
        .res_valid(val_n), .res_data(dat_n), .res_dest(dst_n), .exc_unimpl(exc_n)
    );

    function automatic logic [31:0] mk(input logic [4:0] ra, input logic [4:0] rb,
                                       input logic [4:0] rc, input logic [5:0] ext,
                                       input logic [4:0] mid, input logic [5:0] op);
        return {ra, rb, rc, ext, mid, op};
    endfunction

    // Unsigned product corrected for the sign of the first operand
    function automatic logic [31:0] ref_hi(input logic [31:0] a, input logic [31:0] b);
        logic [63:0] u;
        u = {32'd0, a} * {32'd0, b};
        return u[63:32] - (a[31] ? b : 32'd0);
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic silent(input string req);
        chk(req, "res_valid (mul)", {31'd0, val_m}, 32'd0);
        chk(req, "exc_unimpl (mul)", {31'd0, exc_m}, 32'd0);
        chk(req, "res_valid (nomul)", {31'd0, val_n}, 32'd0);
        chk(req, "exc_unimpl (nomul)", {31'd0, exc_n}, 32'd0);
    endtask

    // Judge the slot issued LAT cycles earlier against its expectation
    task automatic judge(input int k, input string req);
        if (s_v[k] && s_hit[k]) begin
            chk(req, "res_valid R1", {31'd0, val_m}, 32'd1);
            chk(req, "res_data R1", dat_m, ref_hi(s_a[k], s_b[k]));
            chk(req, "res_dest R3", {27'd0, dst_m}, {27'd0, s_instr[k][21:17]});
            chk(req, "exc_unimpl mul R6", {31'd0, exc_m}, 32'd0);
            chk(req, "res_valid nomul R6", {31'd0, val_n}, 32'd0);
            chk(req, "exc_unimpl nomul R6", {31'd0, exc_n}, 32'd1);
            chk(req, "exc dest R3", {27'd0, dst_n}, {27'd0, s_instr[k][21:17]});
        end else begin
            silent(req);
        end
    endtask

    // Stream n slots, checking each output slot LAT cycles after issue
    task automatic pipe_run(input int n, input string req);
        for (int j = 0; j < n + LAT; j++) begin
            @(negedge clk);
            if (j >= LAT) judge(j - LAT, req);
            else          silent({req, " R4 early"});
            if (j < n) begin
                in_valid = s_v[j];
                in_instr = s_instr[j];
                in_op_a  = s_a[j];
                in_op_b  = s_b[j];
            end else begin
                in_valid = 1'b0;
            end
        end
    endtask

    task automatic put(input int k, input logic v, input logic hit, input logic [31:0] w,
                       input logic [31:0] a, input logic [31:0] b);
        s_v[k] = v; s_hit[k] = hit; s_instr[k] = w; s_a[k] = a; s_b[k] = b;
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        silent("R9 in reset");
        chk("R9", "in_ready in reset", {30'd0, rdy_m, rdy_n}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9", "in_ready after reset", {30'd0, rdy_m, rdy_n}, 32'd3);
    endtask

    task automatic t_basic;
        put(0, 1, 1, mk(5'd7, 5'd8, 5'd6,  6'h17, 5'd0, 6'h3a), 32'd7, 32'd3);
        put(1, 1, 1, mk(5'd1, 5'd2, 5'd9,  6'h17, 5'd0, 6'h3a), 32'hFFFFFFFF, 32'd5);
        put(2, 1, 1, mk(5'd3, 5'd4, 5'd31, 6'h17, 5'd0, 6'h3a), 32'h40000000, 32'h10);
        put(3, 1, 1, mk(5'd3, 5'd4, 5'd1,  6'h17, 5'd0, 6'h3a), 32'h7FFFFFFF, 32'hFFFFFFFF);
        put(4, 1, 1, mk(5'd3, 5'd4, 5'd17, 6'h17, 5'd0, 6'h3a), 32'h80000001, 32'h80000000);
        put(5, 0, 0, '0, '0, '0);
        put(6, 1, 1, mk(5'd0, 5'd0, 5'd0,  6'h17, 5'd0, 6'h3a), 32'h12345678, 32'h9ABCDEF0);
        pipe_run(7, "R1 basic");
    endtask

    task automatic t_corner;
        put(0, 1, 1, mk(5'd1, 5'd1, 5'd12, 6'h17, 5'd0, 6'h3a), 32'h80000000, 32'hFFFFFFFF);
        pipe_run(1, "R8 corner");
        chk("R8", "reference high word", ref_hi(32'h80000000, 32'hFFFFFFFF), 32'h80000000);
    endtask

    task automatic t_reject;
        put(0, 1, 0, mk(5'd1, 5'd2, 5'd3, 6'h17, 5'd0,  6'h3b), 32'd9, 32'd9);
        put(1, 1, 0, mk(5'd1, 5'd2, 5'd4, 6'h16, 5'd0,  6'h3a), 32'd9, 32'd9);
        put(2, 1, 1, mk(5'd1, 5'd2, 5'd5, 6'h17, 5'd0,  6'h3a), 32'hFFFFFFFE, 32'hFFFFFFFF);
        put(3, 1, 0, mk(5'd1, 5'd2, 5'd6, 6'h17, 5'd1,  6'h3a), 32'd9, 32'd9);
        put(4, 1, 0, mk(5'd1, 5'd2, 5'd7, 6'h17, 5'd16, 6'h3a), 32'd9, 32'd9);
        put(5, 1, 0, mk(5'd1, 5'd2, 5'd8, 6'h37, 5'd0,  6'h3a), 32'd9, 32'd9);
        pipe_run(6, "R2 R5 reject");
    endtask

    task automatic t_gate;
        put(0, 0, 0, mk(5'd1, 5'd2, 5'd10, 6'h17, 5'd0, 6'h3a), 32'h55, 32'h66);
        put(1, 1, 1, mk(5'd1, 5'd2, 5'd11, 6'h17, 5'd0, 6'h3a), 32'hFFFF0000, 32'h00010000);
        put(2, 0, 0, mk(5'd1, 5'd2, 5'd12, 6'h17, 5'd0, 6'h3a), 32'h77, 32'h88);
        pipe_run(3, "R10 gate");
    endtask

    task automatic t_b2b;
        for (int k = 0; k < 8; k++)
            put(k, 1, 1, mk(5'(k), 5'(k + 1), 5'(k + 20), 6'h17, 5'd0, 6'h3a),
                32'h9E3779B9 * (k + 1), 32'hDEADBEEF ^ (k * 32'h01010101));
        pipe_run(8, "R7 back-to-back");
    endtask

    initial begin
        t_reset;
        t_basic;
        t_corner;
        t_reject;
        t_gate;
        t_b2b;
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: counts as a failure and still prints the summary
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule